// File: doc/BRIEF.md
# Vector Element Load/Store Sequencer

This block carries out one vector memory instruction that uses a short signed
displacement. From the 32-bit instruction word it pulls out a displacement, the
index of the general register that holds the base address, the index of a
128-bit vector register, the element format and the transfer direction. The
format selects byte, halfword, word or doubleword elements. It scales the
displacement and sets the step between element addresses. It also sets how many
elements the 128-bit register splits into.

When `start` is pulsed, the block takes the base value that the surrounding
pipeline supplies in the same cycle. `base_sel` names the register the pipeline
must read for that value. The block computes the effective address and then
makes one memory request per element, in ascending order, waiting for `mem_ready`
on each request. A load assembles every returned element into a lane buffer and
writes the vector register once, at the end. A store reads the vector register
once, at the start, and sends out its lanes one after another.

Top module: `vec_elem_lsu`

## Requirements
- R1: Field decode: displacement = instr[25:16] (signed), base register index = instr[15:11] (driven on `base_sel` combinationally), vector register index = instr[10:6] (driven on `vr_idx` while busy), direction = instr[2] (1 = store, 0 = load), format f = instr[1:0].
- R2: The first element address is the base value plus the sign-extended displacement shifted left by f, computed modulo 2^32.
- R3: Exactly 16 >> f requests are made, and request i goes to the first address plus (i << f).
- R4: `mem_size` equals f on every request (0 byte, 1 halfword, 2 word, 3 doubleword).
- R5: A load places element i, zero-extended from the low 8<<f bits of `mem_rdata`, into vector bits [i*W+W-1 : i*W] with W = 8<<f. It asserts `vr_we` for exactly one cycle, after the last element has returned.
- R6: A store drives lane i of the vector register, zero-extended, on `mem_wdata` with `mem_we` high. It never asserts `vr_we`.
- R7: While `mem_req` is high and `mem_ready` is low, the request's address, size, write data and direction stay unchanged in the next cycle.
- R8: `busy` rises in the cycle after `start` and stays high until `done`. `done` is a one-cycle pulse during which `busy` is already low.
- R9: A `start` pulse that arrives while `busy` is high is ignored and causes no extra request or register write.
- R10: After reset, `busy`, `done`, `mem_req`, `mem_we` and `vr_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 32 | Instruction word |
| base_val | input | AW | Value of the base register, valid with `start` |
| base_sel | output | 5 | Base register index decoded from `instr` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| vr_idx | output | 5 | Vector register index for read and write |
| vr_rdata | input | VLEN | Vector register read data |
| vr_we | output | 1 | Vector register write enable |
| vr_wdata | output | VLEN | Vector register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the element |
| mem_size | output | 2 | log2 of the element byte count |
| mem_wdata | output | EW | Store element, zero-extended |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | EW | Load element data |

## Verification
A `start` pulse can coincide with a cycle in which an element request is being
accepted. The bench provokes this by pulsing `start` with a different
instruction partway through a busy load or store while the memory's ready is
random. The collision is judged by the log of accepted requests, which must hold
only the original instruction's 16 >> f addresses, and by the vector register
file model, which must change only as the original instruction dictates. Ready
held low across cycles is also mixed with the final handshake, to confirm that
requests stay stable and that completion follows only the last acceptance.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {FMT_B = 2'd0, FMT_H = 2'd1, FMT_W = 2'd2, FMT_D = 2'd3} fmt_e;
  typedef enum logic [1:0] {S_IDLE, S_SRC, S_ACC, S_WB} seq_e;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   instr,
  input  logic [AW-1:0] base_val,
  output fmt_e          fmt,
  output logic          is_store,
  output logic [4:0]    vidx,
  output logic [4:0]    gidx,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] disp_x;
  logic          unused_bits;

  assign unused_bits = ^{instr[31:26], instr[5:3]};
  assign fmt         = fmt_e'(instr[1:0]);
  assign is_store    = instr[2];
  assign vidx        = instr[10:6];
  assign gidx        = instr[15:11];
  assign disp_x      = {{(AW-10){instr[25]}}, instr[25:16]};
  assign ea          = base_val + (disp_x << instr[1:0]);
endmodule

// File: rtl/vls_lanes.sv
module vls_lanes
  import vls_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int EW   = 64,
  localparam int IW  = $clog2(VLEN / 8)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [IW-1:0]   idx,
  input  fmt_e            fmt,
  input  logic [EW-1:0]   ins_data,
  output logic [EW-1:0]   ext,
  output logic [VLEN-1:0] ins_vec
);
  logic [EW-1:0]   ext_f [4];
  logic [VLEN-1:0] ins_f [4];

  for (genvar f = 0; f < 4; f++) begin : g_fmt
    localparam int W  = 8 << f;
    localparam int LW = $clog2(VLEN / W);
    logic [LW-1:0] lidx;
    assign lidx = idx[LW-1:0];
    assign ext_f[f] = EW'(vec[lidx*W +: W]);
    always_comb begin
      ins_f[f] = vec;
      ins_f[f][lidx*W +: W] = ins_data[W-1:0];
    end
  end

  assign ext     = ext_f[fmt];
  assign ins_vec = ins_f[fmt];
endmodule

// File: rtl/vec_elem_lsu.sv
module vec_elem_lsu
  import vls_pkg::*;
#(
  parameter int AW   = 32,
  parameter int VLEN = 128,
  parameter int EW   = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [AW-1:0]   base_val,
  output logic [4:0]      base_sel,
  output logic            busy,
  output logic            done,
  output logic [4:0]      vr_idx,
  input  logic [VLEN-1:0] vr_rdata,
  output logic            vr_we,
  output logic [VLEN-1:0] vr_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [EW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [EW-1:0]   mem_rdata
);
  localparam int NB = VLEN / 8;
  localparam int IW = $clog2(NB);

  fmt_e          d_fmt;
  logic          d_st;
  logic [4:0]    d_vidx;
  logic [AW-1:0] d_ea;

  seq_e            state;
  fmt_e            fmt_q;
  logic            st_q;
  logic [4:0]      vidx_q;
  logic [AW-1:0]   addr_q;
  logic [IW-1:0]   cnt_q;
  logic [IW-1:0]   last_idx;
  logic [VLEN-1:0] buf_q;
  logic [VLEN-1:0] ins_vec;
  logic [EW-1:0]   lane_out;
  logic            done_q;

  vls_decode #(.AW(AW)) u_dec (
    .instr(instr), .base_val(base_val), .fmt(d_fmt), .is_store(d_st),
    .vidx(d_vidx), .gidx(base_sel), .ea(d_ea)
  );

  vls_lanes #(.VLEN(VLEN), .EW(EW)) u_lanes (
    .vec(buf_q), .idx(cnt_q), .fmt(fmt_q), .ins_data(mem_rdata),
    .ext(lane_out), .ins_vec(ins_vec)
  );

  assign last_idx = IW'((NB >> fmt_q) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      fmt_q  <= FMT_B;
      st_q   <= 1'b0;
      vidx_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fmt_q  <= d_fmt;
          st_q   <= d_st;
          vidx_q <= d_vidx;
          addr_q <= d_ea;
          cnt_q  <= '0;
          state  <= S_SRC;
        end
        S_SRC: begin
          buf_q <= st_q ? vr_rdata : '0;
          state <= S_ACC;
        end
        S_ACC: if (mem_ready) begin
          if (!st_q) buf_q <= ins_vec;
          addr_q <= addr_q + (AW'(1) << fmt_q);
          if (cnt_q == last_idx) begin
            if (st_q) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= S_WB;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WB: begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign vr_idx    = vidx_q;
  assign vr_we     = (state == S_WB);
  assign vr_wdata  = buf_q;
  assign mem_req   = (state == S_ACC);
  assign mem_we    = mem_req & st_q;
  assign mem_addr  = addr_q;
  assign mem_size  = fmt_q;
  assign mem_wdata = lane_out;
endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
  parameter int AW = 32,
  parameter int EW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          vr_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [EW-1:0] mem_wdata,
  input logic          mem_ready
);
  p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)
                                 && $stable(mem_wdata) && $stable(mem_we)));

  p_stride_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=>
      (!mem_req || mem_addr == $past(mem_addr) + (AW'(1) << $past(mem_size))));

  p_size_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_size == $past(mem_size)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_wb_then_done_r5: assert property (@(posedge clk) disable iff (rst)
    vr_we |=> (done && !vr_we));

  p_wb_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    vr_we |-> (busy && !mem_req));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !mem_we && !vr_we));
endmodule

bind vec_elem_lsu vls_chk #(.AW(AW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .vr_we(vr_we),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/tb_vec_elem_lsu.sv
module tb_vec_elem_lsu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int VLEN = 128;
  localparam int EW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] instr = '0;
  logic [AW-1:0] base_val = '0;
  logic [4:0] base_sel, vr_idx;
  logic busy, done, vr_we, mem_req, mem_we, mem_ready;
  logic [VLEN-1:0] vr_rdata, vr_wdata;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [EW-1:0] mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_lsu #(.AW(AW), .VLEN(VLEN), .EW(EW)) dut (.*);

  logic [VLEN-1:0] vregs [32];
  assign vr_rdata = vregs[vr_idx];

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [63:0] pat(input logic [31:0] a, input int f);
    logic [63:0] v = '0;
    for (int k = 0; k < (1 << f); k++) v[k*8 +: 8] = byte_at(a + k);
    return v;
  endfunction

  function automatic logic [63:0] wmask(input int f);
    return (f == 3) ? '1 : ((64'd1 << (8 << f)) - 1);
  endfunction

  // Upper bits carry ones so zero-extension of narrow loads is visible.
  always_comb mem_rdata = pat(mem_addr, int'(mem_size)) | ~wmask(int'(mem_size));

  // Memory responder, access log, stability monitor, register writes.
  logic [31:0] la [16];
  logic [1:0]  ls [16];
  logic [63:0] lw [16];
  logic        lwe [16];
  int n_acc = 0, n_wr = 0, n_done = 0, stab_err = 0;
  logic pend = 1'b0;
  logic [31:0] s_a; logic [1:0] s_s; logic [63:0] s_w; logic s_we;
  int ready_mode = 0;

  always @(negedge clk) begin
    logic rdy;
    if (rst) begin
      mem_ready <= 1'b0;
      pend = 1'b0;
    end else begin
      if (pend && (mem_addr !== s_a || mem_size !== s_s || mem_wdata !== s_w || mem_we !== s_we || !mem_req))
        stab_err++;
      rdy = (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
      mem_ready <= rdy;
      if (mem_req && rdy) begin
        if (n_acc < 16) begin
          la[n_acc] = mem_addr; ls[n_acc] = mem_size; lw[n_acc] = mem_wdata; lwe[n_acc] = mem_we;
        end
        n_acc++;
      end
      pend = mem_req && !rdy;
      s_a = mem_addr; s_s = mem_size; s_w = mem_wdata; s_we = mem_we;
      if (vr_we) begin
        vregs[vr_idx] = vr_wdata;
        n_wr++;
      end
      if (done) n_done++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input bit st, input int f, input logic [4:0] wd,
                                           input logic [9:0] off, input logic [4:0] rs);
    return {6'd30, off, rs, wd, 3'b100, st, f[1:0]};
  endfunction

  task automatic run_op(input bit st, input int f, input logic [4:0] wd, input logic [9:0] off,
                        input logic [31:0] base, input logic [4:0] rs, input bit inject);
    logic [31:0] ea;
    logic [127:0] src, exp_v;
    int cnt, w, cyc;
    bit ok;
    cnt = 16 >> f; w = 8 << f;
    ea = base + ({{22{off[9]}}, off} << f);
    src = vregs[wd];
    exp_v = src;
    n_acc = 0; n_wr = 0; n_done = 0; stab_err = 0;
    @(negedge clk);
    instr = mk_instr(st, f, wd, off, rs); base_val = base; start = 1'b1;
    #1;
    chk(base_sel == rs, "R1 base_sel", 128'(base_sel), 128'(rs));
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", 128'(busy), 128'd1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (inject && cyc == 6) begin
        instr = mk_instr(~st, 3, wd ^ 5'd1, 10'd4, 5'd3); base_val = 32'h100; start = 1'b1;
      end else start = 1'b0;
      if (!done && cyc > 0 && !busy) break;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R8 done with busy low", 128'({done, busy}), 128'b10);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single pulse", 128'(done), 128'd0);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && n_done == 1, inject ? "R9 no restart" : "R8 one completion",
        128'(n_done), 128'd1);
    chk(n_acc == cnt, inject ? "R9 access count" : "R3 access count", 128'(n_acc), 128'(cnt));
    ok = 1;
    for (int i = 0; i < cnt && i < n_acc; i++) if (la[i] !== ea + (i << f)) ok = 0;
    chk(ok, "R2 R3 element addresses", 128'(la[0]), 128'(ea));
    ok = 1;
    for (int i = 0; i < cnt && i < n_acc; i++) if (ls[i] !== f[1:0] || lwe[i] !== st) ok = 0;
    chk(ok, "R4 size and direction", 128'(ls[0]), 128'(f));
    chk(stab_err == 0, "R7 request held while not ready", 128'(stab_err), 128'd0);
    if (st) begin
      ok = 1;
      for (int i = 0; i < cnt && i < n_acc; i++)
        if (lw[i] !== (64'(src >> (i*w)) & wmask(f))) ok = 0;
      chk(ok, "R6 store lane data", 128'(lw[0]), 128'(64'(src) & wmask(f)));
      chk(n_wr == 0 && vregs[wd] === src, "R6 no register write", 128'(n_wr), 128'd0);
    end else begin
      for (int i = 0; i < cnt; i++)
        for (int b = 0; b < w; b++) exp_v[i*w + b] = pat(ea + (i << f), f)[b];
      chk(n_wr == 1, "R5 single register write", 128'(n_wr), 128'd1);
      chk(vregs[wd] === exp_v, "R5 R1 loaded lanes", vregs[wd], exp_v);
    end
    if (inject) chk(vregs[wd ^ 5'd1] === vregs_shadow, "R9 other register untouched",
                    vregs[wd ^ 5'd1], vregs_shadow);
  endtask

  logic [127:0] vregs_shadow;

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    for (int r = 0; r < 32; r++) vregs[r] = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !mem_we && !vr_we, "R10 reset outputs",
        128'({busy, done, mem_req, mem_we, vr_we}), 128'd0);
    rst = 1'b0;
    // directed: every format, both directions, extreme displacements, address wrap
    for (int f = 0; f < 4; f++) begin
      run_op(1'b0, f, 5'd7, 10'h1FF, 32'h0000_1000, 5'd2, 1'b0);
      run_op(1'b1, f, 5'd9, 10'h200, 32'h0000_4000, 5'd5, 1'b0);
    end
    run_op(1'b0, 3, 5'd31, 10'h3FF, 32'h0000_0004, 5'd31, 1'b0);
    ready_mode = 1;
    run_op(1'b1, 0, 5'd0, 10'h001, 32'hFFFF_FFF8, 5'd0, 1'b0);
    run_op(1'b0, 1, 5'd12, 10'h000, 32'h0000_2222, 5'd1, 1'b0);
    ready_mode = 0;
    // start collides with an in-flight instruction
    vregs_shadow = vregs[5'd4 ^ 5'd1];
    run_op(1'b0, 0, 5'd4, 10'h010, 32'h0000_8000, 5'd6, 1'b1);
    vregs_shadow = vregs[5'd10 ^ 5'd1];
    run_op(1'b1, 1, 5'd10, 10'h3F0, 32'h0000_9000, 5'd8, 1'b1);
    // random
    for (int n = 0; n < 40; n++) begin
      run_op(1'($urandom), int'($urandom % 4), 5'($urandom), 10'($urandom), $urandom,
             5'($urandom), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule